// File: doc/BRIEF.md
# Six-Channel Pulse-Width Modulator Bank

This block drives six pulse-width modulated outputs. Each channel is set through two 32-bit registers. The timing word sets the waveform shape as a count of clock cycles spent high and a count spent low. The control word holds an enable bit, a delay held low before the first pulse, and a limit on the number of periods. Software writes and reads these registers through a simple word-wide port. The port has a request strobe and a direction bit. It never stalls, so it has no back-pressure: every request is taken on the clock edge where `reg_valid` is high.

The timing word is a shadow copy. A running channel picks up new timing values only when one period ends and the next begins, so a period in flight is never cut short. The enable bit works the other way. Clearing it pulls the output low at once, and a later enable starts again from the lead-in delay.

Top module: `pwm_bank`

## Requirements
- R1: There are six channels, and each runs on its own. The control word of channel c sits at byte address 4*c. Its timing word sits at byte address 0x20 + 4*c. Address bits 1:0 are ignored.
- R2: Control word layout: bit 31 is the enable, bits 30:16 are the lead-in count L0, and bits 15:0 are the repeat count. Once the enable is set, the output stays low for 1 + L0 cycles and then begins its first period.
- R3: Timing word layout: bits 31:16 are the high count H and bits 15:0 are the low count L. A period is H cycles high followed by L cycles low, so it lasts H + L cycles.
- R4: Clearing the enable pulls the output low in the first cycle after the write edge. Setting the enable again restarts the sequence from the lead-in delay.
- R5: A timing word written while the channel runs leaves the current period unchanged. The new counts apply from the start of the next period.
- R6: A repeat count N greater than zero stops the channel after N periods. The output then stays low while the enable bit is still set, and the enable bit still reads back as set.
- R7: A repeat count of zero makes the periods repeat without end.
- R8: If H is 0, the output stays low. If L is 0 and H is not 0, the output stays high. If both are 0, each period is a single low cycle.
- R9: A read request (`reg_valid` high, `reg_write` low) places the addressed word on `reg_rdata` one cycle later. `reg_rdata` holds its value in all other cycles. Unmapped addresses (control or timing index 6 or 7) read as zero, and writes to them change nothing.
- R10: Reset clears every register, every output and `reg_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access request, accepted every cycle it is high |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 6 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read request |
| pwm_out | output | 6 | One PWM output per channel |

## Verification
The bound checker watches four things on every cycle. A channel whose enable is clear never drives high. The cycle in which an enable rises is always low. An output can only rise if its enable was already set in the cycle before. `reg_rdata` stays still when no read is requested. The per-cycle reference model in the bench is the only thing that can show the exact cycle counts of lead-in, high and low phases. The same goes for when a timing change takes effect, the end of a finite run after its set number of periods, and the constant-level cases.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned LEAD_W = 15;

  typedef enum logic [2:0] {
    PH_OFF, PH_LEAD, PH_HIGH, PH_LOW, PH_DONE
  } phase_t;

  // field positions are fixed: software encodes them
  typedef struct packed {
    logic              en;
    logic [LEAD_W-1:0] lead;
    logic [CNT_W-1:0]  reps;
  } ctrl_t;

  typedef struct packed {
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] lo;
  } timing_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_bank_pkg::*;
#(
  parameter int NCH    = 6,
  parameter int ADDR_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_valid,
  input  logic                   reg_write,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [WORD_W-1:0]      reg_wdata,
  output logic [WORD_W-1:0]      reg_rdata,
  output ctrl_t   [NCH-1:0]      ctrl_o,
  output timing_t [NCH-1:0]      timing_o
);
  localparam int IDX_W = ADDR_W - 3;

  logic             bank_sel;
  logic [IDX_W-1:0] idx;
  logic             hit;
  logic [WORD_W-1:0] rd_word;
  logic             unused_lsb;

  assign bank_sel   = reg_addr[ADDR_W-1];
  assign idx        = reg_addr[ADDR_W-2:2];
  assign hit        = int'(idx) < NCH;
  assign unused_lsb = ^reg_addr[1:0];

  for (genvar g = 0; g < NCH; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrl_o[g]   <= '0;
        timing_o[g] <= '0;
      end else if (reg_valid && reg_write && hit && idx == IDX_W'(g)) begin
        if (bank_sel) timing_o[g] <= reg_wdata;
        else          ctrl_o[g]   <= reg_wdata;
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (hit) rd_word = bank_sel ? timing_o[idx] : ctrl_o[idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       reg_rdata <= '0;
    else if (reg_valid && !reg_write) reg_rdata <= rd_word;
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_bank_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ctrl_t   ctrl_i,
  input  timing_t shadow_i,
  output logic    pwm_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_t           phase, ph_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [CNT_W-1:0] act_lo, lo_n;
  logic [CNT_W-1:0] done_cnt, done_n, done_inc;
  logic [CNT_W-1:0] lead_ext;
  logic             go_start, at_bound;

  assign lead_ext = {1'b0, ctrl_i.lead};
  assign done_inc = done_cnt + ONE;

  always_comb begin
    ph_n     = phase;
    cnt_n    = cnt;
    lo_n     = act_lo;
    done_n   = done_cnt;
    go_start = 1'b0;
    at_bound = 1'b0;
    if (!ctrl_i.en) begin
      ph_n   = PH_OFF;
      cnt_n  = '0;
      done_n = '0;
    end else begin
      unique case (phase)
        PH_OFF: begin
          done_n = '0;
          if (lead_ext != '0) begin
            ph_n  = PH_LEAD;
            cnt_n = lead_ext - ONE;
          end else go_start = 1'b1;
        end
        PH_LEAD: begin
          if (cnt == '0) go_start = 1'b1;
          else           cnt_n = cnt - ONE;
        end
        PH_HIGH: begin
          if (cnt != '0) cnt_n = cnt - ONE;
          else if (act_lo != '0) begin
            ph_n  = PH_LOW;
            cnt_n = act_lo - ONE;
          end else at_bound = 1'b1;
        end
        PH_LOW: begin
          if (cnt != '0) cnt_n = cnt - ONE;
          else           at_bound = 1'b1;
        end
        default: ph_n = PH_DONE;
      endcase
      // end of a period: count it, then stop or go on
      if (at_bound) begin
        if (ctrl_i.reps == '0) go_start = 1'b1;
        else begin
          done_n = done_inc;
          if (done_inc >= ctrl_i.reps) ph_n = PH_DONE;
          else                         go_start = 1'b1;
        end
      end
      // period start: shadow timing becomes active here only
      if (go_start) begin
        lo_n = shadow_i.lo;
        if (shadow_i.hi != '0) begin
          ph_n  = PH_HIGH;
          cnt_n = shadow_i.hi - ONE;
        end else begin
          ph_n  = PH_LOW;
          cnt_n = (shadow_i.lo == '0) ? '0 : shadow_i.lo - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_OFF;
      cnt      <= '0;
      act_lo   <= '0;
      done_cnt <= '0;
    end else begin
      phase    <= ph_n;
      cnt      <= cnt_n;
      act_lo   <= lo_n;
      done_cnt <= done_n;
    end
  end

  // gated by the live enable so a disable acts without waiting for a state edge
  assign pwm_o = ctrl_i.en && (phase == PH_HIGH);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NCH    = 6,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [NCH-1:0]    pwm_out
);
  ctrl_t   [NCH-1:0] ctrl_w;
  timing_t [NCH-1:0] timing_w;
  logic    [NCH-1:0] en_vec;

  pwm_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ctrl_o    (ctrl_w),
    .timing_o  (timing_w)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign en_vec[g] = ctrl_w[g].en;
    pwm_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_i   (ctrl_w[g]),
      .shadow_i (timing_w[g]),
      .pwm_o    (pwm_out[g])
    );
  end
endmodule

// File: rtl/pwm_bank_sva.sv
module pwm_bank_sva #(
  parameter int NCH = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_valid,
  input logic           reg_write,
  input logic [31:0]    reg_rdata,
  input logic [NCH-1:0] pwm_out,
  input logic [NCH-1:0] en_vec
);
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    a_r4_off_is_low: assert property (@(posedge clk) disable iff (!rst_n)
      !en_vec[i] |-> !pwm_out[i]);
    a_r2_enable_cycle_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_vec[i]) |-> !pwm_out[i]);
    a_r2_rise_needs_prior_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_out[i]) |-> $past(en_vec[i]));
  end

  a_r9_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_valid && !reg_write) |=> $stable(reg_rdata));
endmodule

bind pwm_bank pwm_bank_sva #(.NCH(NCH)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_valid (reg_valid),
  .reg_write (reg_write),
  .reg_rdata (reg_rdata),
  .pwm_out   (pwm_out),
  .en_vec    (en_vec)
);

// File: tb/pwm_bank_tb_top.sv
module pwm_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0;
  logic        reg_write = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NCH-1:0] pwm_out;

  int errors = 0;
  int checks = 0;
  string cur_req = "R10";
  bit model_on = 1'b0;

  logic [31:0] ctrl_m [NCH];
  logic [31:0] tim_m  [NCH];
  bit exp_q [NCH][$];
  bit running [NCH];
  bit finished [NCH];
  int periods [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_bank dut_i (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // behavioural reference: a queue of expected output levels per channel
  always @(negedge clk) begin
    if (rst_n && model_on) begin
      for (int c = 0; c < NCH; c++) begin
        bit e;
        e = 1'b0;
        if (!ctrl_m[c][31]) begin
          exp_q[c].delete();
          running[c] = 1'b0;
          finished[c] = 1'b0;
        end else begin
          if (!running[c]) begin
            running[c] = 1'b1;
            finished[c] = 1'b0;
            periods[c] = 0;
            for (int k = 0; k < int'(ctrl_m[c][30:16]); k++) exp_q[c].push_back(1'b0);
          end else if (exp_q[c].size() > 0) e = exp_q[c].pop_front();
          if (exp_q[c].size() == 0 && !finished[c]) begin
            if (ctrl_m[c][15:0] != 0 && periods[c] >= int'(ctrl_m[c][15:0])) finished[c] = 1'b1;
            else begin
              for (int k = 0; k < int'(tim_m[c][31:16]); k++) exp_q[c].push_back(1'b1);
              for (int k = 0; k < int'(tim_m[c][15:0]); k++) exp_q[c].push_back(1'b0);
              if (tim_m[c] == 0) exp_q[c].push_back(1'b0);
              periods[c]++;
            end
          end
        end
        checks++;
        if (pwm_out[c] !== e) begin
          errors++;
          $display("FAIL %s ch%0d cycle output: got %0b expected %0b", cur_req, c, pwm_out[c], e);
        end
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    if (int'(a[4:2]) < NCH) begin
      if (a[5]) tim_m[a[4:2]] = d;
      else      ctrl_m[a[4:2]] = d;
    end
    #1 reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    @(posedge clk);
    #1 reg_valid = 1'b0;
    @(negedge clk);
    check(reg_rdata === exp, req, reg_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      ctrl_m[c] = '0; tim_m[c] = '0; running[c] = 0; finished[c] = 0; periods[c] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pwm_out === '0, "R10", 32'(pwm_out), 0);
    check(reg_rdata === '0, "R10", reg_rdata, 0);
    rst_n = 1'b1;
    model_on = 1'b1;
    rd(6'h00, 0, "R10");
    rd(6'h34, 0, "R10");

    // R2 R3 R7: lead-in then endless 3-high/2-low periods on ch0
    cur_req = "R2";
    wr(6'h20, {16'd3, 16'd2});
    wr(6'h00, {1'b1, 15'd4, 16'd0});
    idle(40);
    cur_req = "R7";
    idle(20);

    // R6: ch1 stops after three periods, enable still reads set
    cur_req = "R6";
    wr(6'h24, {16'd2, 16'd5});
    wr(6'h04, {1'b1, 15'd0, 16'd3});
    idle(40);
    check(pwm_out[1] === 1'b0, "R6", 32'(pwm_out[1]), 0);
    rd(6'h04, {1'b1, 15'd0, 16'd3}, "R6");

    // R5: timing change mid-period on ch2
    cur_req = "R5";
    wr(6'h28, {16'd4, 16'd4});
    wr(6'h08, {1'b1, 15'd2, 16'd0});
    idle(11);
    wr(6'h28, {16'd1, 16'd2});
    idle(30);

    // R4: disable ch0 cuts output, re-enable restarts with lead-in
    cur_req = "R4";
    wr(6'h20, {16'd6, 16'd1});
    idle(10);
    while (pwm_out[0] !== 1'b1) @(posedge clk);
    wr(6'h00, 32'd0);
    @(negedge clk);
    check(pwm_out[0] === 1'b0, "R4", 32'(pwm_out[0]), 0);
    idle(5);
    wr(6'h00, {1'b1, 15'd1, 16'd2});
    idle(30);

    // R8: constant levels
    cur_req = "R8";
    wr(6'h2C, {16'd0, 16'd5});
    wr(6'h30, {16'd5, 16'd0});
    wr(6'h34, {16'd0, 16'd0});
    wr(6'h0C, {1'b1, 15'd0, 16'd0});
    wr(6'h10, {1'b1, 15'd0, 16'd0});
    wr(6'h14, {1'b1, 15'd0, 16'd0});
    idle(30);
    @(negedge clk);
    check(pwm_out[3] === 1'b0, "R8", 32'(pwm_out[3]), 0);
    check(pwm_out[4] === 1'b1, "R8", 32'(pwm_out[4]), 1);
    check(pwm_out[5] === 1'b0, "R8", 32'(pwm_out[5]), 0);

    // R9 R1: reads, aliases and unmapped slots
    cur_req = "R9";
    rd(6'h21, tim_m[0], "R1");
    rd(6'h2B, tim_m[2], "R1");
    rd(6'h18, 0, "R9");
    wr(6'h18, 32'hFFFF_FFFF);
    wr(6'h3C, 32'hFFFF_FFFF);
    rd(6'h18, 0, "R9");
    rd(6'h3C, 0, "R9");
    rd(6'h14, ctrl_m[5], "R9");
    rd(6'h34, tim_m[5], "R9");
    idle(10);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule